// File: doc/BRIEF.md
# Dual Down-Counting Event Timer

This block holds two independent down-counters behind a small register file. Each counter is loaded by software and decrements once per tick until it reaches zero. A timer that is at zero when its next tick arrives expires. Expiry sets that timer's event flag and drives its interrupt line. The timer then either reloads from its own reload register, which gives a periodic event, or stays parked at zero as a one-shot.

Each timer picks its own tick source. It can count on a reference pulse, which arrives as a one-cycle strobe that is synchronous to `clk`. It can also count on the system clock divided by a power of two, with the divider chosen per timer. A free-running elapsed time can be taken as the bitwise inverse of a live count.

Software clears an event flag by writing zero to the flag's bit in the status register. Writing one to a flag bit leaves that flag unchanged. Reads are combinational from the address, so no read strobe is needed.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads zero and both `irq` bits are low.
- R2: Byte offsets: 0x00 control, 0x04 status, 0x10/0x14 reload/value of timer 0, 0x18/0x1C reload/value of timer 1; any other offset reads zero. Control keeps only bits 0..3, 11, 12 and 19..24 (mask 0x01F8180F); other control bits read zero. Reload registers read back what was written.
- R3: Control bit 2t enables timer t. With control bit 11+t clear, the timer decrements once every 2^n cycles, where n is the 3-bit field at bit 19+3t. The divider phase restarts on a value write and is held at its start while the timer is disabled or the reference source is selected.
- R4: With control bit 11+t set, an enabled timer t decrements in each cycle in which `ref_tick` is high.
- R5: A tick while the count is zero expires the timer. Expiry sets status bit 8t in the same edge that the tick is taken. With auto-reload (control bit 2t+1) set, the count reloads from its reload register at that edge, so loading N-1 into both gives an event every N ticks.
- R6: With auto-reload clear, an expired timer stays at zero and raises no further event until it is re-armed. A value write re-arms it, and so does an auto-reload expiry.
- R7: A status write clears each flag whose bit is 0 and keeps each flag whose bit is 1. An expiry in the same cycle wins over the clear.
- R8: A write to a value register loads the count at that edge. It overrides any tick or expiry of that timer in the same cycle. A read of the value register returns the live count.
- R9: `irq[t]` equals the status flag of timer t.
- R10: A disabled timer holds its count.
- R11: Activity, writes and flags of one timer never change the other timer's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the source of the divided tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Reference tick strobe, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 2 | Per-timer interrupt, one bit per timer |

## Verification
A register write takes effect at the clock edge that samples it, and a read shows the new value in the following cycle because the read path has no register. A timer enabled on the divided clock, with its value written V, sets its flag and interrupt (V+1)*2^n cycles after the write edge. The bench drives inputs on the falling edge and advances its reference model on the rising edge from the same inputs. It compares `irq` and the addressed read data on the next falling edge, so every result is checked in the first cycle in which it is due.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NUM_TMR     = 2;
  localparam int DIV_W       = 3;
  localparam int OFF_CTRL    = 'h00;
  localparam int OFF_STAT    = 'h04;
  localparam int OFF_REL0    = 'h10;
  localparam int OFF_VAL0    = 'h14;
  localparam int OFF_STEP    = 8;
  localparam int REF_BIT0    = 11;
  localparam int DIV_LSB0    = 19;
  localparam int FLAG_STEP   = 8;

  function automatic logic [31:0] ctrl_keep_mask();
    logic [31:0] m;
    m = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      m[2*t]                         = 1'b1;
      m[2*t+1]                       = 1'b1;
      m[REF_BIT0+t]                  = 1'b1;
      m[DIV_LSB0+DIV_W*t +: DIV_W]   = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << DIV_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, lim;
  logic [PC_W:0]   pow2;
  logic            pc_en;

  always_comb begin
    pow2   = (PC_W+1)'(1) << div_i;
    lim    = PC_W'(pow2 - 1'b1);
    tick_o = run_i && (pc_q >= lim);
  end

  always_comb begin
    pc_en = run_i || (pc_q != '0) || restart_i;
    if (restart_i || !run_i || tick_o) pc_d = '0;
    else                               pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !restart_i && !tick_o) |=> pc_q == $past(pc_q) + 1'b1);
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_i,
  input  logic             tick_i,
  input  logic             val_we_i,
  input  logic             rel_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rel_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q;
  logic             arm_q, arm_d;
  logic             cnt_en, at_zero;

  always_comb begin
    at_zero  = (cnt_q == '0);
    expire_o = tick_i && !val_we_i && at_zero && (auto_i || arm_q);
    cnt_en   = val_we_i || tick_i;
    if (val_we_i)     cnt_d = wdata_i;
    else if (at_zero) cnt_d = auto_i ? rel_q : '0;
    else              cnt_d = cnt_q - 1'b1;
    if (val_we_i)      arm_d = 1'b1;
    else if (expire_o) arm_d = auto_i;
    else               arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q <= cnt_d;
      if (rel_we_i) rel_q <= wdata_i;
      arm_q <= arm_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rel_o = rel_q;

  // R8
  val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_we_i |=> cnt_q == $past(wdata_i));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !val_we_i && cnt_q == '0 && auto_i) |=> cnt_q == $past(rel_q));
  // R6
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !val_we_i && cnt_q == '0 && !auto_i) |=> cnt_q == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !val_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  output logic [DATA_W-1:0]               reg_rdata,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt_i,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  rel_i,
  input  logic [NUM_TMR-1:0]              expire_i,
  output logic [NUM_TMR-1:0]              en_o,
  output logic [NUM_TMR-1:0]              auto_o,
  output logic [NUM_TMR-1:0]              ref_o,
  output logic [NUM_TMR-1:0][DIV_W-1:0]   div_o,
  output logic [NUM_TMR-1:0]              val_we_o,
  output logic [NUM_TMR-1:0]              rel_we_o,
  output logic [NUM_TMR-1:0]              flag_o
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(ctrl_keep_mask());

  logic [DATA_W-1:0]  ctrl_q, ctrl_d;
  logic [NUM_TMR-1:0] flag_q, flag_d;
  logic               ctrl_we, stat_we;

  always_comb begin
    ctrl_we = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
    stat_we = reg_we && (reg_addr == ADDR_W'(OFF_STAT));
    ctrl_d  = reg_wdata & KEEP;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_comb begin
      en_o[t]     = ctrl_q[2*t];
      auto_o[t]   = ctrl_q[2*t+1];
      ref_o[t]    = ctrl_q[REF_BIT0+t];
      div_o[t]    = ctrl_q[DIV_LSB0+DIV_W*t +: DIV_W];
      val_we_o[t] = reg_we && (reg_addr == ADDR_W'(OFF_VAL0 + OFF_STEP*t));
      rel_we_o[t] = reg_we && (reg_addr == ADDR_W'(OFF_REL0 + OFF_STEP*t));
      flag_d[t]   = expire_i[t] |
                    (flag_q[t] & ~(stat_we & ~reg_wdata[FLAG_STEP*t]));
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i[t] |=> flag_q[t]);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !reg_wdata[FLAG_STEP*t] && !expire_i[t]) |=> !flag_q[t]);
    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[t] && !(stat_we && !reg_wdata[FLAG_STEP*t])) |=> flag_q[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_CTRL)) reg_rdata = ctrl_q;
    if (reg_addr == ADDR_W'(OFF_STAT)) begin
      for (int t = 0; t < NUM_TMR; t++) reg_rdata[FLAG_STEP*t] = flag_q[t];
    end
    for (int t = 0; t < NUM_TMR; t++) begin
      if (reg_addr == ADDR_W'(OFF_REL0 + OFF_STEP*t)) reg_rdata = rel_i[t];
      if (reg_addr == ADDR_W'(OFF_VAL0 + OFF_STEP*t)) reg_rdata = cnt_i[t];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_TMR-1:0] irq
);
  logic [1:0]                       rsync_q;
  logic                             rst_int_n;
  logic [NUM_TMR-1:0][DATA_W-1:0]   cnt, rel;
  logic [NUM_TMR-1:0]               expire, en, auto_rl, ref_sel;
  logic [NUM_TMR-1:0]               val_we, rel_we, flag, div_tick, tick;
  logic [NUM_TMR-1:0][DIV_W-1:0]    div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dtmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt_i     (cnt),
    .rel_i     (rel),
    .expire_i  (expire),
    .en_o      (en),
    .auto_o    (auto_rl),
    .ref_o     (ref_sel),
    .div_o     (div),
    .val_we_o  (val_we),
    .rel_we_o  (rel_we),
    .flag_o    (flag)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dtmr_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .run_i     (en[t] && !ref_sel[t]),
      .restart_i (val_we[t]),
      .div_i     (div[t]),
      .tick_o    (div_tick[t])
    );

    assign tick[t] = en[t] && (ref_sel[t] ? ref_tick : div_tick[t]);

    dtmr_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .auto_i   (auto_rl[t]),
      .tick_i   (tick[t]),
      .val_we_i (val_we[t]),
      .rel_we_i (rel_we[t]),
      .wdata_i  (reg_wdata),
      .cnt_o    (cnt[t]),
      .rel_o    (rel[t]),
      .expire_o (expire[t])
    );

    // R4
    ref_tick_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (en[t] && ref_sel[t] && !ref_tick && !val_we[t]) |=> $stable(cnt[t]));
  end

  assign irq = flag;
endmodule

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEEP = 32'h01F8_180F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ctrl;
  logic [31:0] m_rel [2];
  logic [31:0] m_cnt [2];
  logic [7:0]  m_pc  [2];
  logic        m_arm [2];
  logic        m_flag[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic model_step();
    logic [31:0] c;
    c = m_ctrl;
    for (int t = 0; t < 2; t++) begin
      logic en, au, rs, tk, vwe, rwe, ex;
      int unsigned lim;
      en  = c[2*t];
      au  = c[2*t+1];
      rs  = c[11+t];
      lim = (32'd1 << c[19+3*t +: 3]) - 1;
      vwe = reg_we && reg_addr == 6'(20 + 8*t);
      rwe = reg_we && reg_addr == 6'(16 + 8*t);
      tk  = en && (rs ? ref_tick : (32'(m_pc[t]) >= lim));
      ex  = tk && !vwe && m_cnt[t] == 0 && (au || m_arm[t]);
      m_flag[t] = ex | (m_flag[t] & !(reg_we && reg_addr == 6'd4 && !reg_wdata[8*t]));
      if (vwe || !en || rs || tk) m_pc[t] = '0;
      else                        m_pc[t] = m_pc[t] + 8'd1;
      if (vwe)     m_arm[t] = 1'b1;
      else if (ex) m_arm[t] = au;
      if (vwe)     m_cnt[t] = reg_wdata;
      else if (tk) m_cnt[t] = (m_cnt[t] == 0) ? (au ? m_rel[t] : 32'd0) : m_cnt[t] - 1;
      if (rwe)     m_rel[t] = reg_wdata;
    end
    if (reg_we && reg_addr == 6'd0) m_ctrl = reg_wdata & KEEP;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int t = 0; t < 2; t++) begin
        m_rel[t] = '0; m_cnt[t] = '0; m_pc[t] = '0; m_arm[t] = 1'b0; m_flag[t] = 1'b0;
      end
    end else begin
      model_step();
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00:   return m_ctrl;
      6'h04:   return {23'd0, m_flag[1], 7'd0, m_flag[0]};
      6'h10:   return m_rel[0];
      6'h14:   return m_cnt[0];
      6'h18:   return m_rel[1];
      6'h1C:   return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [5:0] a);
    case (a)
      6'h00:        return "R2 control readback";
      6'h04:        return "R7 status flags";
      6'h10, 6'h18: return "R2 reload readback";
      6'h14, 6'h1C: return "R3/R4/R8/R10/R11 live count";
      default:      return "R2 unmapped offset";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [5:0] a, input logic [31:0] d, input logic rt);
    @(negedge clk);
    chk("R9 irq0 (R5/R6)", 32'(irq[0]), 32'(m_flag[0]));
    chk("R9 irq1 (R5/R6/R11)", 32'(irq[1]), 32'(m_flag[1]));
    reg_we = we; reg_addr = a; reg_wdata = d; ref_tick = rt;
    #1;
    if (!we) chk(rd_tag(a), reg_rdata, exp_rd(a));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] addrs [7];
    addrs = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h08};
    void'($urandom(32'd20240517));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      cycle(1'b0, addrs[i], 32'd0, 1'b0);
      chk("R1 register after reset", reg_rdata, 32'd0);
    end
    chk("R1 irq after reset", 32'(irq), 32'd0);

    // R2 control keeps only defined bits
    cycle(1'b1, 6'h00, 32'hFFFF_FFFF, 1'b0);
    cycle(1'b0, 6'h00, 32'd0, 1'b0);
    chk("R2 control mask", reg_rdata, KEEP);
    cycle(1'b1, 6'h00, 32'd0, 1'b0);

    // R5 periodic timer0, period 4 ticks, divide by 1
    cycle(1'b1, 6'h10, 32'd3, 1'b0);
    cycle(1'b1, 6'h14, 32'd3, 1'b0);
    cycle(1'b1, 6'h00, 32'h0000_0003, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b0, 6'h14, 32'd0, 1'b0);
    @(negedge clk);
    chk("R5 irq0 after N ticks", 32'(irq[0]), 32'd1);
    chk("R5 count reloaded", reg_rdata, 32'd3);
    cycle(1'b1, 6'h04, 32'hFFFF_FFFE, 1'b0);
    cycle(1'b0, 6'h04, 32'd0, 1'b0);
    chk("R7 flag0 cleared by zero", 32'(irq[0]), 32'd0);
    cycle(1'b1, 6'h00, 32'd0, 1'b0);
    cycle(1'b1, 6'h04, 32'hFFFF_FFFE, 1'b0);

    // R6 one-shot timer1, divide by 2, value 2
    cycle(1'b1, 6'h00, 32'h0040_0004, 1'b0);
    cycle(1'b1, 6'h1C, 32'd2, 1'b0);
    for (int i = 0; i < 12; i++) cycle(1'b0, 6'h1C, 32'd0, 1'b0);
    @(negedge clk);
    chk("R6 irq1 after one-shot", 32'(irq[1]), 32'd1);
    chk("R6 count parked at zero", reg_rdata, 32'd0);
    cycle(1'b1, 6'h04, 32'hFFFF_FEFF, 1'b0);
    for (int i = 0; i < 20; i++) cycle(1'b0, 6'h1C, 32'd0, 1'b0);
    @(negedge clk);
    chk("R6 no second event", 32'(irq[1]), 32'd0);
    chk("R11 timer0 untouched", 32'(irq[0]), 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic rt;
      r  = $urandom_range(0, 99);
      rt = ($urandom_range(0, 2) == 0);
      if (r < 4)       cycle(1'b1, 6'h00, $urandom(), rt);
      else if (r < 10) cycle(1'b1, ($urandom_range(0, 1) != 0) ? 6'h1C : 6'h14,
                             32'($urandom_range(0, 24)), rt);
      else if (r < 14) cycle(1'b1, ($urandom_range(0, 1) != 0) ? 6'h18 : 6'h10,
                             32'($urandom_range(0, 24)), rt);
      else if (r < 20) cycle(1'b1, 6'h04, $urandom(), rt);
      else             cycle(1'b0, addrs[$urandom_range(0, 6)], 32'd0, rt);
    end
    cycle(1'b0, 6'h00, 32'd0, 1'b0);
    finish_run();
  end
endmodule